// File: doc/BRIEF.md
# Programmable Power-Good Assertion Delay

This block holds back a power-good output until an internal "supply good" condition has stayed valid for a programmed time. Software writes the delay as a 16-bit word in a compact floating format: a signed exponent and a signed mantissa whose product gives milliseconds. When the word is written, the block converts it into a number of 200 µs ticks, rounding to the nearest tick and clamping at the longest delay the counter supports (13.1 s, 65500 ticks). A free-running tick enable from an internal time base paces the count. No external shared clock is involved.

The control is a three-state machine. **IDLE**: the condition is low and the output is low. **WAIT**: the condition is high and the block counts ticks. **GOOD**: the delay has expired and the output follows the condition. The transitions are these. *arm* (IDLE→WAIT) fires when the condition is high and loads the converted delay. *expire* (WAIT→GOOD) fires on a tick that finds the remaining count at zero. *abort* (WAIT→IDLE) and *release* (GOOD→IDLE) fire when the condition drops. In GOOD, the output falls in the same cycle the condition falls.

Top module: `pg_delay`

## Requirements
- R1: After reset the output is low and the stored delay is zero ticks, so the first tick after the condition rises asserts the output.
- R2: The delay word carries a two's complement exponent N in bits [15:11] and a two's complement mantissa Y in bits [10:0]. The tick count is Y·5·2^N rounded half up, since Y·2^N is in milliseconds and one tick is 200 µs.
- R3: A converted count above 65500 ticks is clamped to 65500.
- R4: A negative mantissa, or a value that rounds to zero ticks, gives zero delay. The output then rises on the first tick after the condition rises.
- R5: With a delay of T ticks, the output rises on the (T+1)-th tick seen while the condition is high, counting from the cycle after the condition rose. It is low before that tick.
- R6: If the condition drops before the delay expires, the count is discarded and the output stays low. The next rise restarts the full delay.
- R7: Once asserted, the output goes low in the same cycle the condition goes low.
- R8: A write to the delay word while counting does not change the count in progress. It applies from the next rise of the condition.
- R9: Only cycles with the tick enable high advance the count. Cycles without a tick leave the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the delay word |
| cfg_wdata | input | 16 | Delay word, exponent in [15:11], mantissa in [10:0] |
| tick | input | 1 | One-cycle 200 µs time-base enable |
| pg_int | input | 1 | Internal power-good condition |
| pg_out | output | 1 | Delayed power-good output |

## Verification
The hardest case to reach is the clamp. It only shows after the full 65500-tick window has run out, so the bench holds the tick enable high every cycle and counts the cycles until the output rises, which keeps the run short enough. A write during an ongoing count is also delicate. The bench issues it a few ticks into a long delay, checks that the first assertion still keeps the old length, and then cycles the condition to show the new length.

// File: rtl/pgd_pkg.sv
package pgd_pkg;
    localparam int WORD_W = 16;
    localparam int EXP_W  = 5;
    localparam int MAN_W  = 11;

    typedef enum logic [1:0] {
        PGD_IDLE = 2'd0,
        PGD_WAIT = 2'd1,
        PGD_GOOD = 2'd2
    } pgd_state_e;
endpackage

// File: rtl/pgd_linear_decode.sv
module pgd_linear_decode
    import pgd_pkg::*;
#(
    parameter int MAX_TICKS = 65500,
    parameter int TICK_W    = $clog2(MAX_TICKS + 1)
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [TICK_W-1:0] ticks_o
);
    localparam int PROD_W = MAN_W + 2;
    localparam int WIDE_W = 48;

    logic [EXP_W-1:0]  exp_f;
    logic [MAN_W-1:0]  man_f;
    logic              man_neg;
    logic [PROD_W-1:0] prod;
    logic [EXP_W-1:0]  rshift;
    logic [WIDE_W-1:0] wide;

    assign exp_f   = word_i[WORD_W-1 -: EXP_W];
    assign man_f   = word_i[MAN_W-1:0];
    assign man_neg = man_f[MAN_W-1];
    // mantissa times five converts milliseconds into 200 us units
    assign prod    = ({2'b00, man_f} << 2) + {2'b00, man_f};
    assign rshift  = (~exp_f) + 1'b1;

    always_comb begin
        wide = '0;
        if (man_neg || prod == '0) begin
            wide = '0;
        end else if (!exp_f[EXP_W-1]) begin
            wide = {{(WIDE_W-PROD_W){1'b0}}, prod} << exp_f[EXP_W-2:0];
        end else begin
            wide = ({{(WIDE_W-PROD_W){1'b0}}, prod}
                    + (WIDE_W'(1) << (rshift - 1'b1))) >> rshift;
        end
    end

    always_comb begin
        if (wide > WIDE_W'(MAX_TICKS)) ticks_o = TICK_W'(MAX_TICKS);
        else                           ticks_o = wide[TICK_W-1:0];
    end
endmodule

// File: rtl/pgd_cfg_hold.sv
module pgd_cfg_hold
    import pgd_pkg::*;
#(
    parameter int MAX_TICKS = 65500,
    parameter int TICK_W    = $clog2(MAX_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [TICK_W-1:0] pending_o
);
    logic [TICK_W-1:0] decoded;

    pgd_linear_decode #(.MAX_TICKS(MAX_TICKS), .TICK_W(TICK_W)) u_dec (
        .word_i  (wdata_i),
        .ticks_o (decoded)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pending_o <= '0;
        else if (we_i) pending_o <= decoded;
    end
endmodule

// File: rtl/pgd_fsm.sv
module pgd_fsm
    import pgd_pkg::*;
#(
    parameter int MAX_TICKS = 65500,
    parameter int TICK_W    = $clog2(MAX_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              cond_i,
    input  logic [TICK_W-1:0] pending_i,
    output pgd_state_e        state_o,
    output logic [TICK_W-1:0] remain_o,
    output logic              good_o
);
    pgd_state_e state_q, state_d;
    logic [TICK_W-1:0] remain_d;

    always_comb begin
        state_d  = state_q;
        remain_d = remain_o;
        unique case (state_q)
            PGD_IDLE: begin
                if (cond_i) begin                 // arm
                    state_d  = PGD_WAIT;
                    remain_d = pending_i;
                end
            end
            PGD_WAIT: begin
                if (!cond_i) begin                // abort
                    state_d  = PGD_IDLE;
                    remain_d = '0;
                end else if (tick_i) begin
                    if (remain_o == '0) state_d = PGD_GOOD;   // expire
                    else                remain_d = remain_o - 1'b1;
                end
            end
            PGD_GOOD: begin
                if (!cond_i) state_d = PGD_IDLE;  // release
            end
            default: state_d = PGD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PGD_IDLE;
            remain_o <= '0;
        end else begin
            state_q  <= state_d;
            remain_o <= remain_d;
        end
    end

    always_comb begin
        good_o  = (state_q == PGD_GOOD) && cond_i;
        state_o = state_q;
    end
endmodule

// File: rtl/pg_delay.sv
module pg_delay
    import pgd_pkg::*;
#(
    parameter int MAX_TICKS = 65500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [15:0] cfg_wdata,
    input  logic        tick,
    input  logic        pg_int,
    output logic        pg_out
);
    localparam int TICK_W = $clog2(MAX_TICKS + 1);

    logic [TICK_W-1:0] pending_ticks;
    logic [TICK_W-1:0] remaining;
    pgd_state_e        fsm_state;

    pgd_cfg_hold #(.MAX_TICKS(MAX_TICKS), .TICK_W(TICK_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (cfg_we),
        .wdata_i   (cfg_wdata),
        .pending_o (pending_ticks)
    );

    pgd_fsm #(.MAX_TICKS(MAX_TICKS), .TICK_W(TICK_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .cond_i    (pg_int),
        .pending_i (pending_ticks),
        .state_o   (fsm_state),
        .remain_o  (remaining),
        .good_o    (pg_out)
    );
endmodule

// File: rtl/pgd_checker.sv
module pgd_checker
    import pgd_pkg::*;
#(
    parameter int MAX_TICKS = 65500,
    parameter int TICK_W    = $clog2(MAX_TICKS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [15:0]       cfg_wdata,
    input logic              tick,
    input logic              pg_int,
    input logic              pg_out,
    input pgd_state_e        fsm_state,
    input logic [TICK_W-1:0] remaining,
    input logic [TICK_W-1:0] pending_ticks
);
    assert_out_needs_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pg_out |-> pg_int);

    assert_drop_keeps_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_int |=> !pg_out);

    assert_rise_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_out) |-> $past(tick));

    assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        remaining <= TICK_W'(MAX_TICKS));

    assert_load_on_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_int && fsm_state == PGD_IDLE) |=> (remaining == $past(pending_ticks)));

    assert_neg_mantissa_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[10]) |=> (pending_ticks == '0));
endmodule

bind pg_delay pgd_checker #(.MAX_TICKS(MAX_TICKS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_wdata     (cfg_wdata),
    .tick          (tick),
    .pg_int        (pg_int),
    .pg_out        (pg_out),
    .fsm_state     (fsm_state),
    .remaining     (remaining),
    .pending_ticks (pending_ticks)
);

// File: tb/pg_delay_tb.sv
module pg_delay_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        tick = 1'b0;
    logic        pg_int = 1'b0;
    logic        pg_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pg_delay u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .tick(tick), .pg_int(pg_int), .pg_out(pg_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input int y, input int n);
        logic [4:0]  nb = n[4:0];
        logic [10:0] yb = y[10:0];
        return {nb, yb};
    endfunction

    // expected ticks from the requirement formula
    function automatic longint model(input int y, input int n);
        longint x, r;
        if (y <= 0) return 0;
        x = longint'(y) * 5;
        if (n >= 0) r = x * (longint'(1) << n);
        else r = (2 * x + (longint'(1) << (-n))) / (longint'(1) << (1 - n));
        if (r > 65500) r = 65500;
        return r;
    endfunction

    task automatic write_word(input logic [15:0] w);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic drop_cond();
        @(negedge clk); pg_int = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // counts ticks until the output rises; gap idle cycles between ticks
    task automatic measure(input int limit, input int gap, input string req, output int n);
        n = 0;
        for (int k = 1; k <= limit; k++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            if (pg_out) begin n = k; break; end
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                if (pg_out) chk(1'b0, req, 1, 0);
            end
        end
    endtask

    task automatic arm_and_measure(input longint exp, input int gap, input string req);
        int n;
        @(negedge clk); pg_int = 1'b1;
        @(negedge clk);
        chk(pg_out == 1'b0, req, pg_out, 0);
        measure(int'(exp) + 3, gap, req, n);
        chk(n == exp + 1, req, n, exp + 1);
    endtask

    task automatic t_reset();
        chk(pg_out == 1'b0, "R1 reset output", pg_out, 0);
        arm_and_measure(0, 0, "R1 reset zero delay");
        drop_cond();
    endtask

    task automatic t_delay(input int y, input int n, input string req);
        longint e = model(y, n);
        write_word(enc(y, n));
        arm_and_measure(e, 0, req);
        @(negedge clk);
        chk(pg_out == 1'b1, {req, " held"}, pg_out, 1);
        pg_int = 1'b0;
        #1;
        chk(pg_out == 1'b0, "R7 same-cycle release", pg_out, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_gap();
        write_word(enc(1, 0));
        arm_and_measure(5, 3, "R9 ticks only advance count");
        drop_cond();
    endtask

    task automatic t_abort();
        int n;
        write_word(enc(3, -1));                // 8 ticks
        @(negedge clk); pg_int = 1'b1;
        @(negedge clk);
        measure(4, 0, "R6 abort", n);
        chk(n == 0, "R6 early count", n, 0);
        pg_int = 1'b0;
        for (int k = 0; k < 12; k++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0;
            chk(pg_out == 1'b0, "R6 low after drop", pg_out, 0);
        end
        arm_and_measure(8, 0, "R6 full restart");
        drop_cond();
    endtask

    task automatic t_write_mid();
        int n;
        write_word(enc(2, 0));                 // 10 ticks
        @(negedge clk); pg_int = 1'b1;
        @(negedge clk);
        measure(3, 0, "R8 pre-write", n);
        chk(n == 0, "R8 pre-write", n, 0);
        write_word(enc(1, 0));                 // 5 ticks
        measure(20, 0, "R8 old length kept", n);
        chk(n == 8, "R8 old length kept", n, 8);
        drop_cond();
        arm_and_measure(5, 0, "R8 new length on next rise");
        drop_cond();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_delay(1, 0, "R2 R5 Y1 N0");
        t_delay(3, -1, "R2 half rounds up");
        t_delay(5, -2, "R2 round down");
        t_delay(1, -3, "R2 small rounds to one");
        t_delay(-1, 0, "R4 negative mantissa");
        t_delay(1, -4, "R4 rounds to zero");
        t_delay(100, 2, "R5 mid delay");
        t_delay(1023, 15, "R3 clamp");
        t_gap();
        t_abort();
        t_write_mid();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 190000 && !done; c++) @(posedge clk);
        if (!done) chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule